// File: doc/BRIEF.md
# Two-Phase Transition-Signalled Word Channel

This block moves data words from a producer to a consumer across a request/acknowledge channel that signals events by transitions, not by levels. The sending half takes a word from a valid/ready push port, drives it onto the channel data bus and inverts the request wire. The receiving half sees the two wires disagree, takes the word when its consumer side allows, and inverts the acknowledge wire to close the transfer. The sending half launches the next word only after that acknowledge transition arrives. Both halves sit in one clock domain. Each handshake wire is held by a C-element style register, so the idle or pending state of the link comes from comparing two wires and not from an explicit state machine.

A build-time parameter selects the receiving half's structure. In the direct form, the pop port is the channel itself, and acknowledge toggles only when the consumer pops. In the buffered form, a one-word holding register takes the word from the channel while the consumer is busy, so acknowledge can return before the pop.

Top module: `hs_channel`

## Requirements
- R1: After reset, `ch_req` and `ch_ack` are both 0, `push_ready` is 1 and `pop_valid` is 0.
- R2: `push_ready` is 1 exactly when `ch_req` equals `ch_ack`. A push (`push_valid` and `push_ready` both high at a clock edge) inverts `ch_req` at that edge, and `ch_req` then holds its new level.
- R3: While `ch_req` differs from `ch_ack`, `ch_data` stays stable from cycle to cycle.
- R4: In the cycle in which `ch_req` takes a new level, `ch_data` already carries the word pushed at that edge.
- R5: When `pop_valid` is high and `pop_ready` is low, `ch_ack` does not change at the next edge. No word is lost or duplicated.
- R6: While a transfer is pending (`ch_req` differs from `ch_ack`), `ch_req` does not change.
- R7: Each handshake wire follows C-element holding behaviour. `ch_ack` changes only to the level `ch_req` had, and `ch_req` changes only from a cycle in which it equalled `ch_ack`.
- R8: Every pushed word is popped exactly once, in push order.
- R9: A word offered on the pop port (`pop_valid` high, `pop_ready` low) is still offered with the same `pop_data` in the next cycle.
- R10: With `RX_BUF`=0, `pop_valid` equals (`ch_req` differs from `ch_ack`) and `pop_data` equals `ch_data`. With `RX_BUF`=1, a pending word that meets an empty holding register is taken at the next edge: `ch_ack` returns to equal `ch_req` and `pop_valid` goes high, whatever `pop_ready` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Producer offers a word |
| push_data | input | DATA_W | Word offered by the producer |
| push_ready | output | 1 | Link is idle and can launch a word |
| ch_req | output | 1 | Request wire, toggled once per launched word |
| ch_ack | output | 1 | Acknowledge wire, toggled once per accepted word |
| ch_data | output | DATA_W | Channel data bus |
| pop_valid | output | 1 | A word is offered to the consumer |
| pop_data | output | DATA_W | Word offered to the consumer |
| pop_ready | input | 1 | Consumer takes the word; low applies backpressure |

## Verification
The bench builds two copies side by side with `DATA_W`=8, one with `RX_BUF`=0 and one with `RX_BUF`=1. This covers both receiver structures, including the case where acknowledge returns while the consumer is still stalled. Each copy carries 320 words whose values come from an arithmetic sequence, so they wrap through the whole 8-bit space. The run steps through four phases of push and pop duty cycle, from free-running to heavily stalled on both sides. Every ordering of push stalls against pop stalls around a pending transfer therefore occurs many times.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic {
        LINK_IDLE    = 1'b0,
        LINK_PENDING = 1'b1
    } link_phase_e;

    typedef struct packed {
        logic req;
        logic ack;
    } link_wires_t;

    // holding element: follow inputs when they agree, else keep state
    function automatic logic c_hold(input logic a, input logic b, input logic prev);
        return (a == b) ? a : prev;
    endfunction

    function automatic link_phase_e link_phase(input link_wires_t w);
        return (w.req != w.ack) ? LINK_PENDING : LINK_IDLE;
    endfunction

endpackage

// File: rtl/hs_celem.sv
module hs_celem #(
    parameter int           WIDTH   = 1,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[i] <= RST_VAL[i];
            else     q[i] <= hs_pkg::c_hold(in_a[i], in_b[i], q[i]);
        end
    end
endmodule

// File: rtl/hs_sender.sv
module hs_sender #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic              req,
    input  logic              ack,
    output logic [DATA_W-1:0] data
);
    import hs_pkg::*;

    link_wires_t wires;
    logic        launch;
    logic        c_a;
    logic        c_b;
    logic [DATA_W-1:0] data_q;

    assign wires.req  = req;
    assign wires.ack  = ack;
    assign push_ready = (link_phase(wires) == LINK_IDLE);
    assign launch     = push_valid & push_ready;

    // both inputs agree on the opposite of ack only when launching
    assign c_a = ~ack;
    assign c_b = launch ? ~ack : req;

    hs_celem #(.WIDTH(1), .RST_VAL(1'b0)) u_req_c (
        .clk (clk),
        .rst (rst),
        .in_a(c_a),
        .in_b(c_b),
        .q   (req)
    );

    always_ff @(posedge clk) begin
        if (rst)         data_q <= '0;
        else if (launch) data_q <= push_data;
    end

    assign data = data_q;
endmodule

// File: rtl/hs_receiver.sv
module hs_receiver #(
    parameter int DATA_W = 8,
    parameter bit RX_BUF = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [DATA_W-1:0] data,
    output logic              ack,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    input  logic              pop_ready
);
    import hs_pkg::*;

    link_wires_t wires;
    logic        pending;
    logic        accept;
    logic        c_a;
    logic        c_b;

    assign wires.req = req;
    assign wires.ack = ack;
    assign pending   = (link_phase(wires) == LINK_PENDING);

    if (RX_BUF) begin : g_buf
        logic              hold_valid;
        logic [DATA_W-1:0] hold_data;
        logic              pop_fire;

        assign pop_fire = hold_valid & pop_ready;
        assign accept   = pending & (~hold_valid | pop_fire);

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_valid <= 1'b0;
                hold_data  <= '0;
            end else if (accept) begin
                hold_valid <= 1'b1;
                hold_data  <= data;
            end else if (pop_fire) begin
                hold_valid <= 1'b0;
            end
        end

        assign pop_valid = hold_valid;
        assign pop_data  = hold_data;
    end else begin : g_direct
        assign accept    = pending & pop_ready;
        assign pop_valid = pending;
        assign pop_data  = data;
    end

    // both inputs agree on req only when the word is taken
    assign c_a = req;
    assign c_b = accept ? req : ack;

    hs_celem #(.WIDTH(1), .RST_VAL(1'b0)) u_ack_c (
        .clk (clk),
        .rst (rst),
        .in_a(c_a),
        .in_b(c_b),
        .q   (ack)
    );
endmodule

// File: rtl/hs_channel.sv
module hs_channel #(
    parameter int DATA_W = 8,
    parameter bit RX_BUF = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_valid,
    input  logic [DATA_W-1:0] push_data,
    output logic              push_ready,
    output logic              ch_req,
    output logic              ch_ack,
    output logic [DATA_W-1:0] ch_data,
    output logic              pop_valid,
    output logic [DATA_W-1:0] pop_data,
    input  logic              pop_ready
);
    hs_sender #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .push_valid(push_valid),
        .push_data (push_data),
        .push_ready(push_ready),
        .req       (ch_req),
        .ack       (ch_ack),
        .data      (ch_data)
    );

    hs_receiver #(.DATA_W(DATA_W), .RX_BUF(RX_BUF)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .req      (ch_req),
        .data     (ch_data),
        .ack      (ch_ack),
        .pop_valid(pop_valid),
        .pop_data (pop_data),
        .pop_ready(pop_ready)
    );
endmodule

// File: rtl/hs_channel_chk.sv
module hs_channel_chk #(
    parameter int DATA_W = 8,
    parameter bit RX_BUF = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              push_valid,
    input logic [DATA_W-1:0] push_data,
    input logic              push_ready,
    input logic              ch_req,
    input logic              ch_ack,
    input logic [DATA_W-1:0] ch_data,
    input logic              pop_valid,
    input logic [DATA_W-1:0] pop_data,
    input logic              pop_ready
);
    a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ch_req && !ch_ack && push_ready && !pop_valid));

    a_r2_push_toggles: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_ready) |=> (ch_req != $past(ch_req)));

    a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
        (($past(ch_req) != $past(ch_ack)) && (ch_req != ch_ack)) |-> $stable(ch_data));

    a_r4_data_first: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_req) |-> (ch_data == $past(push_data)));

    a_r5_backpressure: assert property (@(posedge clk) disable iff (rst)
        (pop_valid && !pop_ready) |=> $stable(ch_ack));

    a_r6_req_held: assert property (@(posedge clk) disable iff (rst)
        (ch_req != ch_ack) |=> $stable(ch_req));

    a_r7_ack_follows: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_ack) |-> (ch_ack == $past(ch_req)));

    a_r7_req_from_idle: assert property (@(posedge clk) disable iff (rst)
        !$stable(ch_req) |-> ($past(ch_req) == $past(ch_ack)));

    a_r9_pop_hold: assert property (@(posedge clk) disable iff (rst)
        (pop_valid && !pop_ready) |=> (pop_valid && $stable(pop_data)));

    if (RX_BUF) begin : g_buf_chk
        a_r10_early_ack: assert property (@(posedge clk) disable iff (rst)
            ((ch_req != ch_ack) && !pop_valid) |=> ((ch_req == ch_ack) && pop_valid));
    end
endmodule

bind hs_channel hs_channel_chk #(.DATA_W(DATA_W), .RX_BUF(RX_BUF)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .push_valid(push_valid),
    .push_data (push_data),
    .push_ready(push_ready),
    .ch_req    (ch_req),
    .ch_ack    (ch_ack),
    .ch_data   (ch_data),
    .pop_valid (pop_valid),
    .pop_data  (pop_data),
    .pop_ready (pop_ready)
);

// File: tb/hs_channel_tb.sv
module hs_channel_tb;
    localparam int DW = 8;
    localparam int NW = 320;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   n_checks = 0;
    int   n_errors = 0;
    logic [1:0] done = 2'b00;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] word_of(input int k);
        return DW'((k * 37 + 11) % (1 << DW));
    endfunction

    for (genvar g = 0; g < 2; g++) begin : g_cfg
        localparam bit BUF = (g == 1);

        logic          pv, pr, prdy, req, ack, popv;
        logic [DW-1:0] pd, cd, popd;

        hs_channel #(.DATA_W(DW), .RX_BUF(BUF)) u_dut (
            .clk       (clk),
            .rst       (rst),
            .push_valid(pv),
            .push_data (pd),
            .push_ready(prdy),
            .ch_req    (req),
            .ch_ack    (ack),
            .ch_data   (cd),
            .pop_valid (popv),
            .pop_data  (popd),
            .pop_ready (pr)
        );

        task automatic chk(input logic ok, input string tag, input int act, input int exp);
            n_checks++;
            if (!ok) begin
                n_errors++;
                $display("FAIL %s cfg%0d: actual %0d expected %0d", tag, g, act, exp);
            end
        endtask

        initial begin
            int pushed = 0;
            int popped = 0;
            int cyc = 0;
            int ph;
            logic p_req, p_ack, p_popv, p_popr;
            logic [DW-1:0] p_cd, p_popd;
            pv = 1'b0; pr = 1'b0; pd = '0;
            @(negedge clk);
            while (rst) @(negedge clk);
            // R1 reset state
            chk(!req && !ack, "R1", {req, ack}, 0);
            chk(prdy == 1'b1, "R1", prdy, 1);
            chk(popv == 1'b0, "R1", popv, 0);
            p_req = 0; p_ack = 0; p_popv = 0; p_popr = 0; p_cd = cd; p_popd = popd;
            while (popped < NW && cyc < 40000) begin
                chk(prdy == (req == ack), "R2", prdy, req == ack);
                if (p_req != p_ack) chk(req == p_req, "R6", req, p_req);
                if (p_req != p_ack && req != ack) chk(cd == p_cd, "R3", cd, p_cd);
                if (req != p_req) chk(cd == word_of(pushed - 1), "R4", cd, word_of(pushed - 1));
                if (p_popv && !p_popr) begin
                    chk(ack == p_ack, "R5", ack, p_ack);
                    chk(popv && popd == p_popd, "R9", popd, p_popd);
                end
                if (ack != p_ack) chk(ack == p_req, "R7", ack, p_req);
                if (BUF) begin
                    if (p_req != p_ack && !p_popv)
                        chk(ack == p_req && popv, "R10", {ack, popv}, {p_req, 1'b1});
                end else begin
                    chk(popv == (req != ack), "R10", popv, req != ack);
                    if (popv) chk(popd == cd, "R10", popd, cd);
                end
                // drive: four duty phases
                ph = (popped * 4) / NW;
                pv = (pushed < NW) && (int'($urandom_range(0, 3)) >= ph);
                pr = (ph == 0) ? 1'b1 : (int'($urandom_range(0, 7)) < 8 - 2 * ph);
                pd = word_of(pushed);
                #1;
                if (popv && pr) begin
                    chk(popd == word_of(popped), "R8", popd, word_of(popped));
                    popped++;
                end
                if (pv && prdy) pushed++;
                p_req = req; p_ack = ack; p_cd = cd; p_popv = popv; p_popr = pr; p_popd = popd;
                @(negedge clk);
                cyc++;
            end
            pv = 1'b0; pr = 1'b0;
            chk(pushed == NW && popped == NW, "R8", popped, NW);
            repeat (3) @(negedge clk);
            chk(!popv && req == ack, "R8", popv, 0);
            done[g] = 1'b1;
        end
    end

    initial begin
        int wd = 0;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        while (done != 2'b11 && wd < 150000) begin
            @(posedge clk);
            wd++;
        end
        if (done != 2'b11) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", done, 3);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule